// File: doc/BRIEF.md
# Gapped clock output generator

This block drives the clock and data output pins of a framed serial transceiver port, one channel for transmit and one for receive. Each channel takes its line clock and a per-bit slot flag from the framer. The flag marks whether the current bit is an overhead bit or a payload bit. When gapping is on, the channel lets the clock reach the pin only during the bit slots that the mode bit selects. Every other slot holds the pin at its idle level. The output then gives exactly one rising edge per selected bit, which suits logic that consumes a plain bit stream with no frame alignment.

Gating is done by OR-ing the line clock with an active-low enable. The enable is registered on the rising edge of the line clock, so it only changes while the clock is high and the OR never makes a runt pulse. The clock pin can be forced to its idle level by a disable bit. Each pin has its own polarity invert, applied after the gating. The data pin is registered. A select bit chooses either the single-register path or a path delayed by further register stages.

Top module: `gapgen_top`

## Requirements
- R1: With gapping on and the pin enabled, a slot whose flag matches the mode bit passes the clock low phase, so the clock pin equals the line clock XOR the clock invert bit during that slot.
- R2: With gapping on and the pin enabled, a slot whose flag does not match the mode bit holds the clock pin at 1 XOR the clock invert bit for the whole slot.
- R3: Mode bit 0 selects slots whose flag is 0 (payload). Mode bit 1 selects slots whose flag is 1 (overhead). The flag and the mode are taken at the rising line-clock edge that starts the slot.
- R4: With gapping off and the pin enabled, the clock pin carries the continuous line clock XOR the clock invert bit.
- R5: With the disable bit set, the clock pin rests at 1 XOR the clock invert bit, whatever the gap, mode and slot inputs are.
- R6: The internal active-low enable changes only while the line clock is high.
- R7: With delay select 0, the data pin equals the data input sampled at the most recent rising line-clock edge, XOR the data invert bit.
- R8: With delay select 1, the data pin equals the data input sampled one rising edge earlier than in R7, XOR the data invert bit.
- R9: Over a frame with fixed configuration, gapping on and no inversion, the number of rising edges on the clock pin equals the number of selected slots.
- R10: While reset is asserted and after it, until the first rising edge, the enable is inactive: with gapping on the clock pin sits at 1 XOR the invert bit, and the data pin equals the data invert bit.
- R11: The transmit channel (index 0) and the receive channel (index 1) are independent: the inputs of one have no effect on the pins of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | NCH | Line clock per channel |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_ovh | input | NCH | Framer flag: 1 = current bit is overhead, 0 = payload |
| ovh_mode | input | NCH | Slot selection: 0 = payload, 1 = overhead |
| gap_on | input | NCH | 1 = gap the clock, 0 = continuous clock |
| clk_off | input | NCH | 1 = force the clock pin to its idle level |
| clk_inv | input | NCH | Clock pin polarity invert |
| data_in | input | NCH | Serial data to be registered onto the data pin |
| dat_inv | input | NCH | Data pin polarity invert |
| dly_sel | input | NCH | 0 = direct registered data, 1 = delayed data path |
| clk_pin | output | NCH | Gapped or continuous clock output |
| dat_pin | output | NCH | Registered data output |

## Verification
The assertions assume that slot flags, mode and data change only some time after a rising line-clock edge and are steady at the next one. They also assume that configuration bits are never changed during a frame whose edges are being counted. The stimulus keeps to this by driving every input in the late low phase, half a nanosecond before the rising edge, from tasks. Random cycles draw every input from a seeded generator. The directed frames hold the configuration fixed for their whole length, so the rising edges on the pin can be counted against the number of selected slots.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

  typedef enum logic {
    SEL_PAYLOAD  = 1'b0,
    SEL_OVERHEAD = 1'b1
  } slot_sel_e;

  // A slot is wanted when its overhead flag matches the selected class.
  function automatic logic slot_enabled(input logic is_ovh, input logic mode);
    return (is_ovh == mode);
  endfunction

  // Raw (pre-polarity) clock level: idle-high when disabled or gated off.
  function automatic logic gated_level(input logic clk, input logic en_n,
                                       input logic gap, input logic off);
    return off | clk | (gap & en_n);
  endfunction

  function automatic logic pin_level(input logic raw, input logic inv);
    return raw ^ inv;
  endfunction

endpackage

// File: rtl/gclk_gate.sv
module gclk_gate
  import gclk_pkg::*;
(
  input  logic src_clk,
  input  logic rst_n,
  input  logic slot_ovh,
  input  logic ovh_mode,
  input  logic gap_on,
  input  logic clk_off,
  input  logic clk_inv,
  output logic clk_pin
);

  logic slot_hit;
  logic en_n_q;
  logic gated_raw;

  assign slot_hit = slot_enabled(slot_ovh, ovh_mode);

  // Registered on the rising edge: the enable only moves while clock is high.
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) en_n_q <= 1'b1;
    else        en_n_q <= ~slot_hit;
  end

  assign gated_raw = gated_level(src_clk, en_n_q, gap_on, clk_off);
  assign clk_pin   = pin_level(gated_raw, clk_inv);

  // Sampled at the rising edge, signals show their low-phase values.
  a_r1_selected_passes: assert property (@(posedge src_clk) disable iff (!rst_n)
    (gap_on && !clk_off && !en_n_q) |-> (clk_pin == clk_inv));

  a_r2_unselected_holds: assert property (@(posedge src_clk) disable iff (!rst_n)
    (gap_on && !clk_off && en_n_q) |-> (clk_pin == !clk_inv));

  a_r4_free_running: assert property (@(posedge src_clk) disable iff (!rst_n)
    (!gap_on && !clk_off) |-> (clk_pin == clk_inv));

  a_r5_disabled_idle: assert property (@(posedge src_clk) disable iff (!rst_n)
    clk_off |-> (clk_pin == !clk_inv));

  // R6: any movement of the enable happens during the high phase.
  always @(en_n_q) begin
    if (rst_n) begin
      a_r6_enable_in_high: assert (src_clk == 1'b1)
        else $error("R6: enable changed while clock low");
    end
  end

endmodule

// File: rtl/gclk_dpath.sv
module gclk_dpath
  import gclk_pkg::*;
#(
  parameter int EXTRA_DLY = 1
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic data_in,
  input  logic dly_sel,
  input  logic dat_inv,
  output logic dat_pin
);

  localparam int STAGES = EXTRA_DLY + 1;

  logic [STAGES-1:0] stage_q;
  logic              picked;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= data_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_dly
    always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign picked  = dly_sel ? stage_q[STAGES-1] : stage_q[0];
  assign dat_pin = pin_level(picked, dat_inv);

  // Cycles since reset, saturating, so $past never reaches before reset.
  logic [1:0] age_q;
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r7_direct_path: assert property (@(posedge src_clk) disable iff (!rst_n)
    (age_q >= 2'd1 && !dly_sel) |-> (dat_pin == ($past(data_in) ^ dat_inv)));

  if (EXTRA_DLY == 1) begin : g_chk_dly
    a_r8_delayed_path: assert property (@(posedge src_clk) disable iff (!rst_n)
      (age_q >= 2'd2 && dly_sel) |-> (dat_pin == ($past(data_in, 2) ^ dat_inv)));
  end

endmodule

// File: rtl/gclk_chan.sv
module gclk_chan #(
  parameter int EXTRA_DLY = 1
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic slot_ovh,
  input  logic ovh_mode,
  input  logic gap_on,
  input  logic clk_off,
  input  logic clk_inv,
  input  logic data_in,
  input  logic dat_inv,
  input  logic dly_sel,
  output logic clk_pin,
  output logic dat_pin
);

  gclk_gate u_gate (
    .src_clk (src_clk),
    .rst_n   (rst_n),
    .slot_ovh(slot_ovh),
    .ovh_mode(ovh_mode),
    .gap_on  (gap_on),
    .clk_off (clk_off),
    .clk_inv (clk_inv),
    .clk_pin (clk_pin)
  );

  gclk_dpath #(.EXTRA_DLY(EXTRA_DLY)) u_dpath (
    .src_clk(src_clk),
    .rst_n  (rst_n),
    .data_in(data_in),
    .dly_sel(dly_sel),
    .dat_inv(dat_inv),
    .dat_pin(dat_pin)
  );

endmodule

// File: rtl/gapgen_top.sv
module gapgen_top #(
  parameter int NCH       = 2,
  parameter int EXTRA_DLY = 1
) (
  input  logic [NCH-1:0] src_clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] slot_ovh,
  input  logic [NCH-1:0] ovh_mode,
  input  logic [NCH-1:0] gap_on,
  input  logic [NCH-1:0] clk_off,
  input  logic [NCH-1:0] clk_inv,
  input  logic [NCH-1:0] data_in,
  input  logic [NCH-1:0] dat_inv,
  input  logic [NCH-1:0] dly_sel,
  output logic [NCH-1:0] clk_pin,
  output logic [NCH-1:0] dat_pin
);

  // R11: one fully separate channel per index (0 = transmit, 1 = receive).
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gclk_chan #(.EXTRA_DLY(EXTRA_DLY)) u_ch (
      .src_clk (src_clk[c]),
      .rst_n   (rst_n),
      .slot_ovh(slot_ovh[c]),
      .ovh_mode(ovh_mode[c]),
      .gap_on  (gap_on[c]),
      .clk_off (clk_off[c]),
      .clk_inv (clk_inv[c]),
      .data_in (data_in[c]),
      .dat_inv (dat_inv[c]),
      .dly_sel (dly_sel[c]),
      .clk_pin (clk_pin[c]),
      .dat_pin (dat_pin[c])
    );
  end

endmodule

// File: tb/sim_gapgen_top.sv
`timescale 1ns/1ps
module sim_gapgen_top;

  localparam int NCH   = 2;
  localparam int FLEN  = 48;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic           rst_n;
  logic [NCH-1:0] slot_ovh, ovh_mode, gap_on, clk_off, clk_inv;
  logic [NCH-1:0] data_in, dat_inv, dly_sel;
  logic [NCH-1:0] clk_pin, dat_pin;

  gapgen_top #(.NCH(NCH), .EXTRA_DLY(1)) u0 (
    .src_clk ({clk, clk}),
    .rst_n   (rst_n),
    .slot_ovh(slot_ovh),
    .ovh_mode(ovh_mode),
    .gap_on  (gap_on),
    .clk_off (clk_off),
    .clk_inv (clk_inv),
    .data_in (data_in),
    .dat_inv (dat_inv),
    .dly_sel (dly_sel),
    .clk_pin (clk_pin),
    .dat_pin (dat_pin)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [NCH-1:0] hist1 = '0, hist2 = '0;

  int  ecnt [NCH];
  bit  cnt_on = 0;
  always @(posedge clk_pin[0]) if (cnt_on) ecnt[0]++;
  always @(posedge clk_pin[1]) if (cnt_on) ecnt[1]++;

  function automatic logic exp_lo(input logic ovh, input logic mode, input logic gap,
                                  input logic off, input logic inv);
    logic wanted;
    wanted = (mode == 1'b1) ? ovh : !ovh;
    if (off)         return !inv;
    else if (!gap)   return inv;
    else if (wanted) return inv;
    else             return !inv;
  endfunction

  function automatic int frame_selected(input logic mode);
    int n = 0;
    for (int s = 0; s < FLEN; s++) if (ovh_of(s) == mode) n++;
    return n;
  endfunction

  function automatic logic ovh_of(input int s);
    return ((s % 12) == 0) || ((s % 12) == 5);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Entered late in the low phase; returns at the same point one cycle on.
  task automatic cycle_check(input string rq_lo);
    logic [NCH-1:0] s, m, g, o, ci, d, di, dl;
    s = slot_ovh; m = ovh_mode; g = gap_on; o = clk_off; ci = clk_inv;
    d = data_in; di = dat_inv; dl = dly_sel;
    @(posedge clk);
    hist2 = hist1; hist1 = d;
    #1;
    for (int c = 0; c < NCH; c++) begin
      chk("R5/R1 high phase", clk_pin[c], !ci[c]);
      if (dl[c]) chk("R8 delayed data", dat_pin[c], hist2[c] ^ di[c]);
      else       chk("R7 direct data",  dat_pin[c], hist1[c] ^ di[c]);
    end
    #2;
    for (int c = 0; c < NCH; c++)
      chk(rq_lo, clk_pin[c], exp_lo(s[c], m[c], g[c], o[c], ci[c]));
    #0.5;
  endtask

  task automatic rand_inputs();
    slot_ovh = NCH'($urandom); ovh_mode = NCH'($urandom);
    gap_on   = NCH'($urandom); clk_off  = NCH'($urandom & $urandom);
    clk_inv  = NCH'($urandom); data_in  = NCH'($urandom);
    dat_inv  = NCH'($urandom); dly_sel  = NCH'($urandom);
  endtask

  task automatic run_frame(input logic mode0, input logic mode1);
    gap_on = '1; clk_off = '0; clk_inv = '0; ovh_mode = {mode1, mode0};
    // preamble slot: unselected on both channels
    slot_ovh = {!mode1, !mode0};
    cycle_check("R2 preamble hold");
    ecnt[0] = 0; ecnt[1] = 0; cnt_on = 1;
    for (int s = 0; s < FLEN; s++) begin
      slot_ovh = {ovh_of(s), ovh_of(s)};
      data_in  = NCH'($urandom);
      cycle_check("R3 frame slot");
    end
    slot_ovh = {!mode1, !mode0};
    cycle_check("R2 postamble hold");
    cnt_on = 0;
    n_chk++;
    if (ecnt[0] != frame_selected(mode0)) begin
      n_fail++;
      $display("FAIL R9 ch0 edges: actual=%0d expected=%0d", ecnt[0], frame_selected(mode0));
    end
    n_chk++;
    if (ecnt[1] != frame_selected(mode1)) begin
      n_fail++;
      $display("FAIL R9/R11 ch1 edges: actual=%0d expected=%0d", ecnt[1], frame_selected(mode1));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    rst_n = 1'b0;
    slot_ovh = '0; ovh_mode = '0; gap_on = '1; clk_off = '0; clk_inv = 2'b10;
    data_in = '1; dat_inv = 2'b01; dly_sel = '0;
    repeat (2) @(posedge clk);
    #3;
    // R10: reset state, sampled in the low phase
    chk("R10 reset clk ch0", clk_pin[0], 1'b1);
    chk("R10 reset clk ch1", clk_pin[1], 1'b0);
    chk("R10 reset data ch0", dat_pin[0], 1'b1);
    chk("R10 reset data ch1", dat_pin[1], 1'b0);
    #0.5;
    rst_n = 1'b1;

    // Directed: R4 free-running, both polarities
    gap_on = '0; clk_off = '0; clk_inv = 2'b01; data_in = 2'b01; dly_sel = '0;
    cycle_check("R4 continuous clock");
    clk_inv = 2'b10; data_in = 2'b10;
    cycle_check("R4 continuous clock inverted");
    // Directed: R5 disabled beats a selected slot
    clk_off = '1; gap_on = '1; slot_ovh = '0; ovh_mode = '0; clk_inv = 2'b01;
    cycle_check("R5 disabled idle");
    // Directed: R11, ch0 selected, ch1 unselected
    clk_off = '0; ovh_mode = 2'b10; slot_ovh = 2'b00; clk_inv = '0;
    cycle_check("R11 channel independence");
    // Directed: R8 delayed path on alternating data
    dly_sel = '1; data_in = 2'b01;
    cycle_check("R8 delayed setup");
    data_in = 2'b10;
    cycle_check("R8 delayed data");

    run_frame(1'b0, 1'b1);
    run_frame(1'b1, 1'b0);

    for (int k = 0; k < 3000; k++) begin
      rand_inputs();
      cycle_check("R1/R2/R3/R5 random slot");
    end

    run_frame(1'b1, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule